// File: doc/BRIEF.md
# Playback Status and LED Output Port

This block drives a single general-purpose output pin from the playback state of a voice player. A static configuration selects whether the pin reports status or drives an LED, a 2-bit option chooses one of four behaviours within that group, and a variant bit picks between two forms of options that exist in two flavours. From reset until the first playback starts, the pin holds a configurable initial level.

A small state machine follows the player. It has four states. `ST_INIT` is the state after reset, before any playback. `ST_PLAY` means playback is running. `ST_IDLE` means playback ended without a stop indication. `ST_DONE` means playback ended with a stop indication. The transitions are:
- INIT→PLAY, IDLE→PLAY and DONE→PLAY when `busy_i` is sampled high.
- PLAY→DONE when `busy_i` is sampled low while `stop_i` is high.
- PLAY→IDLE when `busy_i` is sampled low while `stop_i` is low.
- Every other case holds the current state.

The pin is a Moore output of this state. It also uses a blink phase that counts timebase ticks and a registered comparison of an audio magnitude against fixed thresholds. Configuration is expected to change only while reset is asserted.

Top module: `status_led_port`

## Requirements
- R1: During reset, and in every cycle until `busy_i` is first sampled high on a clock edge, `pin_o` equals `init_lvl_i`. All later requirements apply only after that edge. The state changes on the edge at which `busy_i` is sampled, and `pin_o` follows in the same cycle.
- R2: Status mode (`led_sel_i`=0), `opt_i`=0: `pin_o` is 1 in PLAY and 0 in IDLE or DONE.
- R3: Status mode, `opt_i`=1: `pin_o` is constantly 0.
- R4: Status mode, `opt_i`=2, `variant_i`=0: `pin_o` is 1 only in DONE, which is entered when playback ends with `stop_i` high. It is 0 in PLAY and IDLE.
- R5: Status mode, `opt_i`=2, `variant_i`=1: `pin_o` is 0 in PLAY and 1 in IDLE or DONE.
- R6: Status mode, `opt_i`=3: `pin_o` is constantly 1.
- R7: LED mode (`led_sel_i`=1), `opt_i`=0 (fast) or 1 (slow): a blink phase is 0 outside PLAY. In PLAY it toggles on the clock edge that completes every 4th (fast) or 16th (slow) cycle with `tick_i` high. In PLAY, `pin_o` is the inverted phase for `variant_i`=0 and the phase itself for `variant_i`=1. Outside PLAY, `pin_o` is 1.
- R8: LED mode, `opt_i`=2: each clock edge registers whether the 8-bit unsigned `mag_i` is strictly greater than 178 (`variant_i`=0, 7/10 of full scale) or 229 (`variant_i`=1, 9/10). In PLAY, `pin_o` shows that registered result. Outside PLAY, `pin_o` is 1.
- R9: LED mode, `opt_i`=3: `pin_o` is constantly 0 for `variant_i`=0 (off) and constantly 1 for `variant_i`=1 (on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Playback in progress |
| stop_i | input | 1 | Stop or completion indication, sampled when busy falls |
| tick_i | input | 1 | Slow timebase tick, one cycle wide |
| mag_i | input | MAG_W (8) | Unsigned audio magnitude |
| led_sel_i | input | 1 | 0 selects status modes, 1 selects LED modes |
| opt_i | input | 2 | Option within the selected group |
| variant_i | input | 1 | Per-port variant bit |
| init_lvl_i | input | 1 | Pin level from reset until the first playback |
| pin_o | output | 1 | Output pin level |

## Verification
If the state register is wrong, every status mode shows it in the same cycle. A missed PLAY→DONE shows up as a missing high in the stop-high mode, and a stuck INIT shows up as the initial level persisting past the first busy. A blink counter that is off by one moves the LED phase edge one tick early or late, so the error appears within 4 or 16 ticks of the start of playback. A wrong threshold is visible one cycle after a magnitude of 178/179 or 229/230. The bench drives exactly these boundary values.

// File: rtl/sled_pkg.sv
package sled_pkg;
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_PLAY = 2'd2,
        ST_DONE = 2'd3
    } play_st_e;
endpackage

// File: rtl/sled_play_fsm.sv
module sled_play_fsm
    import sled_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy_i,
    input  logic     stop_i,
    output play_st_e state_o
);
    play_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (busy_i) state_d = ST_PLAY;
            ST_IDLE: if (busy_i) state_d = ST_PLAY;
            ST_PLAY: if (!busy_i) state_d = stop_i ? ST_DONE : ST_IDLE;
            ST_DONE: if (busy_i) state_d = ST_PLAY;
        endcase
    end

    assign state_o = state_q;

    // R4: an end of playback with stop raised lands in DONE
    a_r4_stop_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAY && !busy_i && stop_i) |=> (state_q == ST_DONE));
    // R1: the initial state is left only through busy
    a_r1_init_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && !busy_i) |=> (state_q == ST_INIT));
endmodule

// File: rtl/sled_blink_gen.sv
module sled_blink_gen #(
    parameter int FAST_TICKS = 4,
    parameter int SLOW_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic slow_i,
    output logic phase_o
);
    localparam int MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_TICKS - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          phase_q;

    assign lim = slow_i ? SLOW_LIM : FAST_LIM;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == lim) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;

    // R7: phase is cleared outside playback
    a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !phase_o);
    // R7: phase moves only on a tick
    a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(phase_o));
endmodule

// File: rtl/sled_level_det.sv
module sled_level_det #(
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             hi_sel_i,
    output logic             over_o
);
    localparam int FULL = (1 << MAG_W) - 1;
    localparam logic [MAG_W-1:0] THR_LO = MAG_W'((7 * FULL) / 10);
    localparam logic [MAG_W-1:0] THR_HI = MAG_W'((9 * FULL) / 10);

    logic over_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) over_q <= 1'b0;
        else        over_q <= mag_i > (hi_sel_i ? THR_HI : THR_LO);
    end

    assign over_o = over_q;

    // R8: silence never lights, full scale always lights
    a_r8_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_i == '0) |=> !over_o);
    a_r8_full_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_i == '1) |=> over_o);
endmodule

// File: rtl/status_led_port.sv
module status_led_port
    import sled_pkg::*;
#(
    parameter int MAG_W      = 8,
    parameter int FAST_TICKS = 4,
    parameter int SLOW_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             led_sel_i,
    input  logic [1:0]       opt_i,
    input  logic             variant_i,
    input  logic             init_lvl_i,
    output logic             pin_o
);
    play_st_e state;
    logic     in_play;
    logic     phase;
    logic     over;
    logic     pin;

    sled_play_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_i),
        .stop_i  (stop_i),
        .state_o (state)
    );

    assign in_play = (state == ST_PLAY);

    sled_blink_gen #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (in_play),
        .tick_i  (tick_i),
        .slow_i  (opt_i[0]),
        .phase_o (phase)
    );

    sled_level_det #(.MAG_W(MAG_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .mag_i    (mag_i),
        .hi_sel_i (variant_i),
        .over_o   (over)
    );

    always_comb begin
        pin = init_lvl_i;
        if (state != ST_INIT) begin
            unique case ({led_sel_i, opt_i})
                3'b000: pin = in_play;
                3'b001: pin = 1'b0;
                3'b010: pin = variant_i ? !in_play : (state == ST_DONE);
                3'b011: pin = 1'b1;
                3'b100,
                3'b101: pin = in_play ? (variant_i ? phase : !phase) : 1'b1;
                3'b110: pin = in_play ? over : 1'b1;
                3'b111: pin = variant_i;
            endcase
        end
    end

    assign pin_o = pin;

    // R3: low-constant status option
    a_r3_const_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_sel_i && opt_i == 2'd1 && state != ST_INIT) |-> !pin_o);
    // R6: high-constant status option
    a_r6_const_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_sel_i && opt_i == 2'd3 && state != ST_INIT) |-> pin_o);
    // R9: LED on/off follows the variant
    a_r9_led_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sel_i && opt_i == 2'd3 && state != ST_INIT) |-> (pin_o == variant_i));
    // R2: busy-high status rises once playback is seen
    a_r2_busy_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_sel_i && opt_i == 2'd0 && busy_i) |=> pin_o);
endmodule

// File: tb/status_led_port_tb.sv
`timescale 1ns/1ps
module status_led_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0, stop = 1'b0, tick = 1'b0;
    logic [7:0] mag = 8'd0;
    logic       led_sel = 1'b0, variant = 1'b0, init_lvl = 1'b0;
    logic [1:0] opt = 2'd0;
    logic       pin;

    int tests = 0, fails = 0;
    int m_st = 0;      // 0 init, 1 idle, 2 play, 3 done
    int m_cnt = 0;
    bit m_ph = 0, m_dyn = 0;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    status_led_port u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .stop_i(stop), .tick_i(tick),
        .mag_i(mag), .led_sel_i(led_sel), .opt_i(opt), .variant_i(variant),
        .init_lvl_i(init_lvl), .pin_o(pin)
    );

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ph = 0; m_dyn = 0;
        end else begin
            int per;
            per = opt[0] ? 16 : 4;
            if (m_st != 2) begin m_cnt = 0; m_ph = 0; end
            else if (tick) begin
                m_cnt++;
                if (m_cnt == per) begin m_cnt = 0; m_ph = !m_ph; end
            end
            m_dyn = variant ? (mag > 8'd229) : (mag > 8'd178);
            if (m_st == 2) begin
                if (!busy) m_st = stop ? 3 : 1;
            end else if (busy) m_st = 2;
        end
    end

    function automatic bit expect_pin();
        bit play;
        play = (m_st == 2);
        if (m_st == 0) return init_lvl;
        if (!led_sel) begin
            if (opt == 0) return play;
            if (opt == 1) return 0;
            if (opt == 3) return 1;
            if (variant) return !play;
            return m_st == 3;
        end
        if (opt == 3) return variant;
        if (!play) return 1;
        if (opt == 2) return m_dyn;
        return variant ? m_ph : !m_ph;
    endfunction

    function automatic string tag();
        if (m_st == 0) return "R1";
        if (!led_sel) begin
            if (opt == 0) return "R2";
            if (opt == 1) return "R3";
            if (opt == 3) return "R6";
            return variant ? "R5" : "R4";
        end
        if (opt == 3) return "R9";
        if (opt == 2) return "R8";
        return "R7";
    endfunction

    task automatic check();
        bit e;
        e = expect_pin();
        tests++;
        if (pin !== e) begin
            fails++;
            $display("FAIL %s cfg led=%0d opt=%0d var=%0d: pin=%b expected=%b at %0t",
                     tag(), led_sel, opt, variant, pin, e, $time);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            rst_n = 1'b0;
            led_sel = k[4]; opt = k[3:2]; variant = k[1]; init_lvl = k[0];
            busy = 0; stop = 0; tick = 0; mag = 0;
            for (int r = 0; r < 3; r++) begin @(negedge clk); check(); end  // R1 in reset
            rst_n = 1'b1;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                check();
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                busy = ((c % 100) >= 10 && (c % 100) < 85) || ((c % 100) >= 92 && (c % 100) < 95);
                stop = lf[3] & lf[7];
                tick = lf[0] | lf[5];
                case (c % 9)
                    0: mag = 8'd178;
                    1: mag = 8'd179;
                    2: mag = 8'd229;
                    3: mag = 8'd230;
                    4: mag = 8'd0;
                    5: mag = 8'd255;
                    default: mag = lf[15:8];
                endcase
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule